// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block decides which analog channel is converted next and when. A channel-enable bitmask picks up to 19 inputs. A direction bit sets the walk through the set bits: from the lowest channel number upward, or from the highest downward. The order always follows channel number. An external trigger line, qualified by a selectable edge, starts work. A mode field sets how much work one trigger starts: a full pass over the list, one channel, a programmed group of channels, or an endless loop over the list.

Each conversion is handed to a behavioural converter model. The model returns a result after a latency set by a shared sample-time selection plus a fixed conversion time. The sequencer presents each result with its channel number and a one-cycle valid strobe. It keeps a sticky end-of-sequence flag that is cleared by writing one, and it drives two interrupt requests that are gated by enable inputs. A change to the mask or to the direction aborts the conversion in flight and rewinds to the start of the new list.

The control FSM has two states. ST_IDLE waits for a qualified trigger; the transition "launch" moves it to ST_CONV. ST_CONV waits for the converter. On each completion it either takes "chain", staying in ST_CONV and launching the next channel, or takes "settle" back to ST_IDLE. The transition "abort" leaves ST_CONV for ST_IDLE on reconfiguration.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `cfg_scan_down`=0, channels are converted in ascending channel-number order through the set bits of `cfg_chan_mask`, and only selected channels are ever reported on `res_chan`.
- R2: With `cfg_scan_down`=1, the set bits are walked in descending channel-number order, starting from the highest selected channel.
- R3: Mode 0 (full pass): one trigger converts every selected channel once, sets `eos_flag` together with the last result, then returns to waiting with `busy` low.
- R4: Mode 1 (stepped): each trigger converts exactly one channel. The next selected channel stays pending for the next trigger, the last channel of the list sets `eos_flag`, and the trigger after that starts again from the first channel.
- R5: Mode 2 (grouped): each trigger converts `cfg_group_len` channels, a value of 0 acting as 1. A group stops early at the end of the list, where `eos_flag` is set, and the next trigger starts from the first channel.
- R6: Mode 3 (looping): one trigger starts conversions that never stop. The list wraps to its first channel, and `eos_flag` is set on every last channel.
- R7: `cfg_trig_edge` selects the trigger edge: 0 never triggers, 1 rising, 2 falling, 3 both edges of `trig_in`.
- R8: Any change of `cfg_chan_mask` or `cfg_scan_down` aborts the running conversion, which then produces no result. `busy` drops, and the next trigger starts from the first channel of the new list.
- R9: A trigger edge that arrives while `busy` is high is dropped, not queued.
- R10: With an all-zero mask, triggers are ignored: no result and no `eos_flag`.
- R11: The result strobe rises on the (S+C+1)-th rising clock edge after the edge that samples the trigger. C is 12, and S for `cfg_smp_sel` 0..7 is 2, 8, 14, 29, 42, 56, 72, 240 cycles.
- R12: `res_valid` is a one-cycle pulse, and `res_data` equals (channel*97+3) modulo 2^12 as returned by the converter model.
- R13: `eos_flag` resets to 0 and stays set until a cycle with `eos_clr`=1. A new end-of-sequence in that same cycle keeps it set. `eos_irq` = `eos_flag` AND `eos_ie`, and `eoc_irq` = `res_valid` AND `eoc_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chan_mask | input | 19 | One enable bit per channel |
| cfg_scan_down | input | 1 | 1 = descending channel order |
| cfg_mode | input | 2 | 0 full pass, 1 stepped, 2 grouped, 3 looping |
| cfg_trig_edge | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| cfg_group_len | input | 5 | Channels per trigger in grouped mode (0 acts as 1) |
| cfg_smp_sel | input | 3 | Sample-time selection shared by all channels |
| trig_in | input | 1 | External trigger line |
| eoc_ie | input | 1 | Enable for the per-conversion interrupt |
| eos_ie | input | 1 | Enable for the end-of-sequence interrupt |
| eos_clr | input | 1 | Write-one clear of the end-of-sequence flag |
| res_valid | output | 1 | One-cycle strobe with a new result |
| res_chan | output | 5 | Channel number of the result |
| res_data | output | 12 | Conversion result |
| eos_flag | output | 1 | Sticky end-of-sequence flag |
| eoc_irq | output | 1 | Per-conversion interrupt request |
| eos_irq | output | 1 | End-of-sequence interrupt request |
| busy | output | 1 | A conversion is in flight |

## Verification
A corrupted position pointer shows up as a wrong channel number on the very next result strobe, and it also moves the end-of-sequence flag to the wrong result. A scoreboard that knows the expected channel order and the list-end markers catches it at the first conversion after the fault. A wrong FSM state shows as conversions that run after a stepped or grouped trigger should have stopped, or as a dead trigger. It is seen within one conversion latency as an unexpected result or a missing one. Latency faults in the converter model are caught by counting cycles from the trigger to the strobe for several sample-time selections.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SCAN  = 2'd0,
        MODE_STEP  = 2'd1,
        MODE_GROUP = 2'd2,
        MODE_LOOP  = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } trig_edge_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_e;

    localparam int SMP_SEL_W   = 3;
    localparam int SMP_MAX_CYC = 240;

    // Sample window length in converter clocks (half cycles rounded up).
    function automatic int unsigned smp_cycles(input logic [SMP_SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 2;
            3'd1:    return 8;
            3'd2:    return 14;
            3'd3:    return 29;
            3'd4:    return 42;
            3'd5:    return 56;
            3'd6:    return 72;
            default: return SMP_MAX_CYC;
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] edge_sel,
    output logic       evt
);
    logic trig_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    assign rise = trig_in & ~trig_q;
    assign fall = ~trig_in & trig_q;

    always_comb begin
        unique case (trig_edge_e'(edge_sel))
            EDGE_OFF:  evt = 1'b0;
            EDGE_RISE: evt = rise;
            EDGE_FALL: evt = fall;
            EDGE_BOTH: evt = rise | fall;
        endcase
    end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
    parameter int NUM_CH = 19,
    parameter int CW     = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [CW-1:0]     start,
    input  logic              start_ok,
    input  logic              down,
    output logic              found,
    output logic [CW-1:0]     ch
);
    // Nearest selected channel at or beyond 'start' in the walk direction.
    always_comb begin
        found = 1'b0;
        ch    = '0;
        if (start_ok) begin
            if (!down) begin
                for (int i = NUM_CH - 1; i >= 0; i--) begin
                    if (mask[i] && (i >= int'(start))) begin
                        found = 1'b1;
                        ch    = CW'(i);
                    end
                end
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (mask[i] && (i <= int'(start))) begin
                        found = 1'b1;
                        ch    = CW'(i);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 19,
    parameter int RES_W    = 12,
    parameter int CONV_CYC = 12,
    parameter int CW       = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abort,
    input  logic [CW-1:0]        ch,
    input  logic [SMP_SEL_W-1:0] smp_sel,
    output logic                 busy,
    output logic                 done,
    output logic [RES_W-1:0]     data
);
    localparam int MAX_LAT = SMP_MAX_CYC + CONV_CYC;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CW-1:0]    ch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
            ch_q  <= '0;
            data  <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy  <= 1'b1;
                ch_q  <= ch;
                cnt_q <= CNT_W'(smp_cycles(smp_sel) + CONV_CYC - 1);
            end else if (busy) begin
                if (cnt_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    data <= RES_W'(int'(ch_q) * 97 + 3);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 19,
    parameter int RES_W    = 12,
    parameter int CONV_CYC = 12,
    parameter int CW       = $clog2(NUM_CH),
    parameter int GW       = $clog2(NUM_CH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    cfg_chan_mask,
    input  logic                 cfg_scan_down,
    input  logic [1:0]           cfg_mode,
    input  logic [1:0]           cfg_trig_edge,
    input  logic [GW-1:0]        cfg_group_len,
    input  logic [SMP_SEL_W-1:0] cfg_smp_sel,
    input  logic                 trig_in,
    input  logic                 eoc_ie,
    input  logic                 eos_ie,
    input  logic                 eos_clr,
    output logic                 res_valid,
    output logic [CW-1:0]        res_chan,
    output logic [RES_W-1:0]     res_data,
    output logic                 eos_flag,
    output logic                 eoc_irq,
    output logic                 eos_irq,
    output logic                 busy
);
    localparam logic [CW-1:0] TOP_CH = CW'(NUM_CH - 1);

    seq_state_e state, state_nxt;
    scan_mode_e mode;

    logic [NUM_CH-1:0] mask_q;
    logic              dir_q;
    logic              reconf;
    logic [CW-1:0]     ptr, cur_ch, list_start, after_start, nxt_ch, start_ch;
    logic              after_ok;
    logic [GW-1:0]     grp_cnt, grp_next, glen_eff;
    logic              trig_evt, accept, seq_end, keep_going, done_ok, conv_start;
    logic              pend_found, after_found, first_found;
    logic [CW-1:0]     pend_ch, after_ch, first_ch;
    logic              cv_busy, cv_done;
    logic [RES_W-1:0]  cv_data;

    assign mode        = scan_mode_e'(cfg_mode);
    assign reconf      = (cfg_chan_mask != mask_q) || (cfg_scan_down != dir_q);
    assign list_start  = cfg_scan_down ? TOP_CH : '0;
    assign after_start = cfg_scan_down ? cur_ch - 1'b1 : cur_ch + 1'b1;
    assign after_ok    = cfg_scan_down ? (cur_ch != '0) : (cur_ch != TOP_CH);

    adc_trig_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .edge_sel (cfg_trig_edge),
        .evt      (trig_evt)
    );

    adc_chan_pick #(.NUM_CH(NUM_CH), .CW(CW)) u_pick_pend (
        .mask (cfg_chan_mask), .start (ptr), .start_ok (1'b1),
        .down (cfg_scan_down), .found (pend_found), .ch (pend_ch)
    );

    adc_chan_pick #(.NUM_CH(NUM_CH), .CW(CW)) u_pick_after (
        .mask (cfg_chan_mask), .start (after_start), .start_ok (after_ok),
        .down (cfg_scan_down), .found (after_found), .ch (after_ch)
    );

    adc_chan_pick #(.NUM_CH(NUM_CH), .CW(CW)) u_pick_first (
        .mask (cfg_chan_mask), .start (list_start), .start_ok (1'b1),
        .down (cfg_scan_down), .found (first_found), .ch (first_ch)
    );

    adc_conv_stub #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CONV_CYC(CONV_CYC), .CW(CW)) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (conv_start),
        .abort   (reconf),
        .ch      (start_ch),
        .smp_sel (cfg_smp_sel),
        .busy    (cv_busy),
        .done    (cv_done),
        .data    (cv_data)
    );

    // Sequencing decisions
    assign accept   = (state == ST_IDLE) && trig_evt && pend_found && !reconf;
    assign done_ok  = (state == ST_CONV) && cv_done && !reconf;
    assign seq_end  = !after_found;
    assign nxt_ch   = seq_end ? first_ch : after_ch;
    assign grp_next = grp_cnt + 1'b1;
    assign glen_eff = (cfg_group_len == '0) ? GW'(1) : cfg_group_len;

    always_comb begin
        unique case (mode)
            MODE_SCAN:  keep_going = !seq_end;
            MODE_STEP:  keep_going = 1'b0;
            MODE_GROUP: keep_going = !seq_end && (grp_next < glen_eff);
            MODE_LOOP:  keep_going = first_found;
        endcase
    end

    assign conv_start = accept || (done_ok && keep_going);
    assign start_ch   = accept ? pend_ch : nxt_ch;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions: launch, chain, settle, abort
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept) state_nxt = ST_CONV;
            ST_CONV: begin
                if (reconf)                      state_nxt = ST_IDLE;
                else if (cv_done && !keep_going) state_nxt = ST_IDLE;
            end
        endcase
    end

    // Position, group count and result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            dir_q     <= 1'b0;
            ptr       <= '0;
            cur_ch    <= '0;
            grp_cnt   <= '0;
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
            eos_flag  <= 1'b0;
        end else begin
            mask_q    <= cfg_chan_mask;
            dir_q     <= cfg_scan_down;
            res_valid <= done_ok;
            if (reconf) begin
                ptr <= list_start;
            end else if (accept) begin
                cur_ch  <= pend_ch;
                grp_cnt <= '0;
            end else if (done_ok) begin
                ptr <= nxt_ch;
                if (keep_going) begin
                    cur_ch  <= nxt_ch;
                    grp_cnt <= grp_next;
                end
            end
            if (done_ok) begin
                res_chan <= cur_ch;
                res_data <= cv_data;
            end
            if (done_ok && seq_end) eos_flag <= 1'b1;
            else if (eos_clr)       eos_flag <= 1'b0;
        end
    end

    assign eoc_irq = res_valid & eoc_ie;
    assign eos_irq = eos_flag & eos_ie;
    assign busy    = (state == ST_CONV);

    AST_RES_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !reconf) |-> cfg_chan_mask[res_chan]); // R1
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chan_mask == '0) |=> !res_valid); // R10
    AST_EOS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        eos_clr |=> (!eos_flag || res_valid)); // R13
    AST_RES_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R12
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reconf) |=> !busy); // R8
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int NUM_CH = 19;

    typedef struct {
        int ch;
        bit last;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] cfg_chan_mask = '0;
    logic              cfg_scan_down = 1'b0;
    logic [1:0]        cfg_mode = 2'd0;
    logic [1:0]        cfg_trig_edge = 2'd1;
    logic [4:0]        cfg_group_len = '0;
    logic [2:0]        cfg_smp_sel = '0;
    logic              trig_in = 1'b0;
    logic              eoc_ie = 1'b1;
    logic              eos_ie = 1'b0;
    logic              eos_clr;
    logic              mon_clr = 1'b0;
    logic              man_clr = 1'b0;
    logic              res_valid;
    logic [4:0]        res_chan;
    logic [11:0]       res_data;
    logic              eos_flag, eoc_irq, eos_irq, busy;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    n_res   = 0;
    int    pos     = 0;
    bit    auto_clr = 1'b1;
    string cur_req = "R0";
    exp_t  exp_q[$];

    assign eos_clr = mon_clr | man_clr;

    always #4 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_chan_mask (cfg_chan_mask), .cfg_scan_down (cfg_scan_down),
        .cfg_mode (cfg_mode), .cfg_trig_edge (cfg_trig_edge),
        .cfg_group_len (cfg_group_len), .cfg_smp_sel (cfg_smp_sel),
        .trig_in (trig_in), .eoc_ie (eoc_ie), .eos_ie (eos_ie), .eos_clr (eos_clr),
        .res_valid (res_valid), .res_chan (res_chan), .res_data (res_data),
        .eos_flag (eos_flag), .eoc_irq (eoc_irq), .eos_irq (eos_irq), .busy (busy)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor: pops the scoreboard on every result strobe
    always @(negedge clk) begin
        mon_clr = 1'b0;
        if (rst_n && res_valid) begin
            n_res++;
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected result chan"}, int'(res_chan), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(res_chan) == e.ch, {cur_req, " channel order"}, int'(res_chan), e.ch);
                check(int'(res_data) == (e.ch * 97 + 3) % 4096, "R12 result data",
                      int'(res_data), (e.ch * 97 + 3) % 4096);
                check(eos_flag == e.last, {cur_req, " end-of-sequence marker"},
                      int'(eos_flag), int'(e.last));
                check(eoc_irq == eoc_ie, "R13 eoc_irq gating", int'(eoc_irq), int'(eoc_ie));
                if (auto_clr && eos_flag) mon_clr = 1'b1;
            end
        end
    end

    // Reference channel list for the current configuration
    function automatic void build_list(ref int lst[$]);
        lst.delete();
        if (!cfg_scan_down) begin
            for (int i = 0; i < NUM_CH; i++) if (cfg_chan_mask[i]) lst.push_back(i);
        end else begin
            for (int i = NUM_CH - 1; i >= 0; i--) if (cfg_chan_mask[i]) lst.push_back(i);
        end
    endfunction

    // Driver side: push what one trigger must produce
    task automatic expect_trig(input int loops);
        int lst[$];
        int n;
        int g;
        build_list(lst);
        n = lst.size();
        if (n == 0) return;
        case (cfg_mode)
            2'd0: begin
                for (int k = 0; k < n; k++) exp_q.push_back('{lst[k], k == n - 1});
                pos = 0;
            end
            2'd1: begin
                exp_q.push_back('{lst[pos], pos == n - 1});
                pos = (pos + 1) % n;
            end
            2'd2: begin
                g = (cfg_group_len == 0) ? 1 : int'(cfg_group_len);
                for (int k = 0; k < g; k++) begin
                    exp_q.push_back('{lst[pos], pos == n - 1});
                    if (pos == n - 1) begin
                        pos = 0;
                        break;
                    end
                    pos++;
                end
            end
            default: begin
                for (int k = 0; k < loops; k++) begin
                    exp_q.push_back('{lst[pos], pos == n - 1});
                    pos = (pos + 1) % n;
                end
            end
        endcase
    endtask

    task automatic configure(input logic [NUM_CH-1:0] m, input logic d, input logic [1:0] md,
                             input logic [1:0] ed, input logic [4:0] gl, input logic [2:0] sm);
        @(negedge clk);
        cfg_chan_mask = '0;
        @(negedge clk);
        cfg_chan_mask = m;
        cfg_scan_down = d;
        cfg_mode      = md;
        cfg_trig_edge = ed;
        cfg_group_len = gl;
        cfg_smp_sel   = sm;
        pos = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_trig(input logic v);
        @(negedge clk);
        trig_in = v;
    endtask

    task automatic pulse();
        set_trig(1'b1);
        set_trig(1'b0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic measure(input logic [2:0] sel, input int exp_cyc);
        int cnt;
        configure(19'h00020, 1'b0, 2'd1, 2'd1, 5'd0, sel);
        expect_trig(0);
        @(negedge clk);
        trig_in = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!res_valid && cnt < 400);
        check(cnt == exp_cyc, "R11 trigger-to-result latency", cnt, exp_cyc);
        trig_in = 1'b0;
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R13";
        check(res_valid == 1'b0, "R13 reset res_valid", int'(res_valid), 0);
        check(eos_flag == 1'b0, "R13 reset eos_flag", int'(eos_flag), 0);
        check(busy == 1'b0, "R13 reset busy", int'(busy), 0);
        check(eos_irq == 1'b0, "R13 reset eos_irq", int'(eos_irq), 0);

        // R1 ascending full pass
        cur_req = "R1";
        configure(19'h40089, 1'b0, 2'd0, 2'd1, 5'd0, 3'd0);
        expect_trig(0); pulse(); drain();

        // R2 descending
        cur_req = "R2";
        configure(19'h40089, 1'b1, 2'd0, 2'd1, 5'd0, 3'd0);
        expect_trig(0); pulse(); drain();

        // R3 full pass stops and waits, then repeats
        cur_req = "R3";
        configure(19'h00C12, 1'b0, 2'd0, 2'd1, 5'd0, 3'd0);
        base = n_res;
        expect_trig(0); pulse(); drain();
        repeat (40) @(negedge clk);
        check(n_res - base == 4, "R3 results per trigger", n_res - base, 4);
        check(busy == 1'b0, "R3 waiting after pass", int'(busy), 0);
        expect_trig(0); pulse(); drain();

        // R4 stepped: one per trigger, wrap after last
        cur_req = "R4";
        configure(19'h00214, 1'b0, 2'd1, 2'd1, 5'd0, 3'd0);
        for (int t = 0; t < 4; t++) begin
            base = n_res;
            expect_trig(0); pulse(); drain();
            repeat (20) @(negedge clk);
            check(n_res - base == 1, "R4 one conversion per trigger", n_res - base, 1);
        end

        // R5 grouped, size 2, then size 0 acting as 1
        cur_req = "R5";
        configure(19'h0006E, 1'b0, 2'd2, 2'd1, 5'd2, 3'd0);
        for (int t = 0; t < 4; t++) begin
            expect_trig(0); pulse(); drain();
        end
        configure(19'h00110, 1'b0, 2'd2, 2'd1, 5'd0, 3'd0);
        base = n_res;
        expect_trig(0); pulse(); drain();
        repeat (30) @(negedge clk);
        check(n_res - base == 1, "R5 group length zero acts as one", n_res - base, 1);

        // R6 looping, stopped by reconfiguration
        cur_req = "R6";
        configure(19'h00003, 1'b0, 2'd3, 2'd1, 5'd0, 3'd0);
        expect_trig(6);
        pulse();
        while (exp_q.size() != 0) @(negedge clk);
        cfg_chan_mask = '0;
        base = n_res;
        repeat (60) @(negedge clk);
        check(n_res == base, "R6 loop halted by reconfiguration", n_res - base, 0);
        check(busy == 1'b0, "R6 idle after stop", int'(busy), 0);

        // R7 edge selection
        cur_req = "R7";
        configure(19'h00008, 1'b0, 2'd1, 2'd2, 5'd0, 3'd0);
        base = n_res;
        set_trig(1'b1);
        repeat (40) @(negedge clk);
        check(n_res == base, "R7 rising edge ignored in falling mode", n_res - base, 0);
        expect_trig(0); set_trig(1'b0); drain();
        configure(19'h00008, 1'b0, 2'd1, 2'd3, 5'd0, 3'd0);
        base = n_res;
        expect_trig(0); set_trig(1'b1); drain();
        expect_trig(0); set_trig(1'b0); drain();
        check(n_res - base == 2, "R7 both edges trigger", n_res - base, 2);
        configure(19'h00008, 1'b0, 2'd1, 2'd0, 5'd0, 3'd0);
        base = n_res;
        pulse();
        repeat (40) @(negedge clk);
        check(n_res == base, "R7 edge select zero disables", n_res - base, 0);

        // R9 trigger while busy is dropped
        cur_req = "R9";
        configure(19'h00006, 1'b0, 2'd0, 2'd1, 5'd0, 3'd7);
        base = n_res;
        expect_trig(0); pulse();
        repeat (5) @(negedge clk);
        check(busy == 1'b1, "R9 busy during conversion", int'(busy), 1);
        pulse();
        drain();
        repeat (300) @(negedge clk);
        check(n_res - base == 2, "R9 second trigger not queued", n_res - base, 2);

        // R8 reconfiguration aborts and restarts
        cur_req = "R8";
        configure(19'h0000E, 1'b0, 2'd0, 2'd1, 5'd0, 3'd7);
        base = n_res;
        pulse();
        repeat (10) @(negedge clk);
        cfg_chan_mask = 19'h00060;
        pos = 0;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R8 abort drops busy", int'(busy), 0);
        repeat (300) @(negedge clk);
        check(n_res == base, "R8 aborted conversion gives no result", n_res - base, 0);
        expect_trig(0); pulse(); drain();
        configure(19'h000E0, 1'b0, 2'd1, 2'd1, 5'd0, 3'd0);
        expect_trig(0); pulse(); drain();
        cfg_scan_down = 1'b1;
        pos = 0;
        repeat (2) @(negedge clk);
        expect_trig(0); pulse(); drain();

        // R10 empty mask
        cur_req = "R10";
        configure(19'h00000, 1'b0, 2'd0, 2'd1, 5'd0, 3'd0);
        base = n_res;
        pulse();
        repeat (40) @(negedge clk);
        check(n_res == base, "R10 no result with empty mask", n_res - base, 0);
        check(eos_flag == 1'b0, "R10 no eos with empty mask", int'(eos_flag), 0);

        // R11 latency per sample-time selection
        cur_req = "R11";
        measure(3'd0, 16);
        measure(3'd1, 22);
        measure(3'd7, 254);

        // R13 sticky flag, write-one clear, interrupt gating
        cur_req = "R13";
        auto_clr = 1'b0;
        eoc_ie = 1'b0;
        configure(19'h00004, 1'b0, 2'd0, 2'd1, 5'd0, 3'd0);
        expect_trig(0); pulse(); drain();
        repeat (10) @(negedge clk);
        check(eos_flag == 1'b1, "R13 flag stays set", int'(eos_flag), 1);
        check(eos_irq == 1'b0, "R13 eos_irq masked", int'(eos_irq), 0);
        eos_ie = 1'b1;
        @(negedge clk);
        check(eos_irq == 1'b1, "R13 eos_irq enabled", int'(eos_irq), 1);
        man_clr = 1'b1;
        @(negedge clk);
        man_clr = 1'b0;
        check(eos_flag == 1'b0, "R13 write-one clear", int'(eos_flag), 0);
        check(eos_irq == 1'b0, "R13 eos_irq follows flag", int'(eos_irq), 0);
        auto_clr = 1'b1;

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R1 scoreboard empty at end", exp_q.size(), 0);
        finish_run();
    end
endmodule